// File: doc/BRIEF.md
# LPC Host Cycle Sequencer

This block is the host side of a Low Pin Count bus. It takes one operation descriptor at a time and carries it out on the bus. The descriptor gives the direction, the cycle kind (I/O, memory or firmware-hub), whether the address advances, a 32-bit address, a firmware-hub ID-select nibble and a byte count. The block drives the frame strobe and the 4-bit LAD lines with an output enable. For writes it takes bytes from a show-ahead transmit FIFO. For reads it delivers bytes to a receive FIFO. Each byte is a complete bus cycle of its own. The whole block runs on the bus clock.

When the last byte completes, or the target reports an error, or the target stays silent too long, the block returns to idle. It then raises a one-clock completion pulse together with a success or failure flag. Its current phase is always visible as a 4-bit status number, so a controller or a debugger can follow the bus cycle.

Top module: `lpc_cycle_seq`

## Requirements
- R1: After reset the status reads 0 (idle), the frame strobe is high, LAD is not driven and no completion pulse is shown.
- R2: `cmd_ready` is high only in idle. A descriptor is taken on a clock where `cmd_valid` and `cmd_ready` are both high. A descriptor offered while busy is ignored and leaves the running bus cycle unchanged.
- R3: Each byte's cycle opens with one clock of frame strobe low. LAD carries 0000 for I/O and memory, 1101 for a firmware-hub read and 1110 for a firmware-hub write. Kind codes: 0 I/O, 1 memory, 2 firmware-hub.
- R4: The next clock (status 2) drives {kind bits, write, 0} for I/O and memory, where the kind bits are 00 for I/O and 01 for memory and write is 1 for a write. For firmware-hub it drives the ID-select nibble.
- R5: The address follows in status 3, most significant nibble first. I/O sends 4 nibbles (bits 15:0), memory 8 and firmware-hub 7 (bits 27:0). Firmware-hub then sends one size nibble 0000 in status 4.
- R6: A write sends its byte low nibble first over two clocks in status 5. `tx_pop` pulses on the second clock. The host turnaround (status 6) drives 1111 for one clock and then releases LAD for one clock.
- R7: In status 7, LAD is released and sampled on each clock. 0000 ends the wait, 1010 sends the block to abort, and any other value keeps waiting.
- R8: If the 256th status-7 clock of a byte still sees neither 0000 nor 1010, the block goes to abort. 0000 on that clock is still accepted.
- R9: A read captures the byte low nibble first over two clocks in status 8. On the second clock it pulses `rx_push` with the assembled byte on `rx_data`.
- R10: Every cycle ends with two released clocks in status 9. The next byte starts at once. Its address is unchanged when `cmd_incr` is 0, and one higher when `cmd_incr` is 1.
- R11: Abort (status 10) holds the frame strobe low with LAD at 1111 for four clocks and then returns to idle. The remaining bytes are dropped: none is popped or pushed.
- R12: `done` is high for exactly the first idle clock after the operation. `err` is high with it after an abort, and `ok` is high with it otherwise.
- R13: `seq_state` numbers the phases 0 idle, 1 start, 2 kind/direction, 3 address, 4 size, 5 write data, 6 host turnaround, 7 sync, 8 read data, 9 target turnaround, 10 abort.
- R14: A descriptor with a byte count of 0 produces no bus activity. It completes with `done` and `ok` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Descriptor offered |
| cmd_ready | output | 1 | Block is idle and takes a descriptor |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_kind | input | 2 | 0 I/O, 1 memory, 2 firmware-hub |
| cmd_incr | input | 1 | 1 advances the address after each byte |
| cmd_idsel | input | 4 | Firmware-hub ID-select nibble |
| cmd_addr | input | 32 | Start address |
| cmd_len | input | LEN_W | Byte count |
| tx_data | input | 8 | Head byte of the transmit FIFO |
| tx_pop | output | 1 | Head byte consumed |
| rx_data | output | 8 | Received byte |
| rx_push | output | 1 | Received byte valid |
| lframe_n | output | 1 | Frame strobe, active low |
| lad_out | output | 4 | LAD value driven by the host |
| lad_oe | output | 1 | Host drives LAD |
| lad_in | input | 4 | LAD value seen on the bus |
| seq_state | output | 4 | Current phase number |
| done | output | 1 | Operation finished |
| ok | output | 1 | Finished without abort |
| err | output | 1 | Finished through abort |

## Verification
A wrong phase in this sequencer shows up on `seq_state` and on the LAD nibble during the same clock, because both outputs are decoded straight from the phase register. A wrong nibble counter or address cursor therefore changes a driven nibble in the first address or data clock that follows. A fault in the wait counter stays hidden until the 256th sync clock. For that reason the waits just below and just at the limit are exercised. A cursor that fails to drop the remaining bytes after an abort shows up at the next completion pulse, or as an extra FIFO pop.

// File: rtl/lpc_seq_pkg.sv
package lpc_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_START  = 4'd1,
    ST_TYPDIR = 4'd2,
    ST_ADDR   = 4'd3,
    ST_MSIZE  = 4'd4,
    ST_WDATA  = 4'd5,
    ST_TARH   = 4'd6,
    ST_SYNC   = 4'd7,
    ST_RDATA  = 4'd8,
    ST_TART   = 4'd9,
    ST_ABORT  = 4'd10
  } seq_state_e;

  typedef enum logic [1:0] {
    KIND_IO   = 2'd0,
    KIND_MEM  = 2'd1,
    KIND_FWH  = 2'd2,
    KIND_RSVD = 2'd3
  } cyc_kind_e;

  localparam logic [3:0] NIB_ZERO     = 4'h0;
  localparam logic [3:0] NIB_ONES     = 4'hF;
  localparam logic [3:0] NIB_FWH_RD   = 4'hD;
  localparam logic [3:0] NIB_FWH_WR   = 4'hE;
  localparam logic [3:0] NIB_SYNC_OK  = 4'h0;
  localparam logic [3:0] NIB_SYNC_ERR = 4'hA;

  // opening nibble shown while the frame strobe is low
  function automatic logic [3:0] start_nibble(cyc_kind_e k, logic wr);
    if (k == KIND_FWH) return wr ? NIB_FWH_WR : NIB_FWH_RD;
    return NIB_ZERO;
  endfunction

  // second nibble: kind/direction, or ID-select for firmware-hub
  function automatic logic [3:0] typedir_nibble(cyc_kind_e k, logic wr, logic [3:0] idsel);
    if (k == KIND_FWH) return idsel;
    return {(k == KIND_MEM) ? 2'b01 : 2'b00, wr, 1'b0};
  endfunction

  // how many address nibbles each kind sends
  function automatic logic [3:0] addr_nibbles(cyc_kind_e k);
    case (k)
      KIND_MEM: return 4'd8;
      KIND_FWH: return 4'd7;
      default:  return 4'd4;
    endcase
  endfunction

  function automatic logic [3:0] nibble_of(logic [31:0] a, logic [2:0] idx);
    return a[{idx, 2'b00} +: 4];
  endfunction

endpackage

// File: rtl/lpc_seq_cursor.sv
module lpc_seq_cursor #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [31:0]      ld_addr,
  input  logic [LEN_W-1:0] ld_len,
  input  logic             ld_incr,
  input  logic             step,
  output logic [31:0]      addr,
  output logic             last
);
  logic [31:0]      addr_q;
  logic [LEN_W-1:0] left_q;
  logic             incr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
      incr_q <= 1'b0;
    end else if (load) begin
      addr_q <= ld_addr;
      left_q <= ld_len;
      incr_q <= ld_incr;
    end else if (step) begin
      left_q <= left_q - LEN_W'(1);
      if (incr_q) addr_q <= addr_q + 32'd1;
    end
  end

  assign addr = addr_q;
  assign last = (left_q == LEN_W'(1));
endmodule

// File: rtl/lpc_sync_watch.sv
module lpc_sync_watch
  import lpc_seq_pkg::*;
#(
  parameter int SYNC_LIMIT = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_sync,
  input  logic [3:0] lad_in,
  output logic       ready,
  output logic       error,
  output logic       timeout
);
  localparam int CW = $clog2(SYNC_LIMIT + 1);
  logic [CW-1:0] wait_q;

  assign ready   = in_sync && (lad_in == NIB_SYNC_OK);
  assign error   = in_sync && (lad_in == NIB_SYNC_ERR);
  assign timeout = in_sync && !ready && !error && (wait_q == CW'(SYNC_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wait_q <= '0;
    else if (!in_sync) wait_q <= '0;
    else               wait_q <= wait_q + CW'(1);
  end
endmodule

// File: rtl/lpc_lad_drive.sv
module lpc_lad_drive
  import lpc_seq_pkg::*;
#(
  parameter int PH_W = 3
) (
  input  seq_state_e      state,
  input  logic [PH_W-1:0] ph,
  input  cyc_kind_e       kind,
  input  logic            wr,
  input  logic [3:0]      idsel,
  input  logic [31:0]     addr,
  input  logic [7:0]      wdata,
  output logic            lframe_n,
  output logic [3:0]      lad_out,
  output logic            lad_oe
);
  logic [2:0] nib_idx;
  assign nib_idx = 3'(addr_nibbles(kind) - 4'd1) - 3'(ph);

  always_comb begin
    lframe_n = 1'b1;
    lad_oe   = 1'b0;
    lad_out  = NIB_ONES;
    unique case (state)
      ST_START: begin
        lframe_n = 1'b0;
        lad_oe   = 1'b1;
        lad_out  = start_nibble(kind, wr);
      end
      ST_TYPDIR: begin
        lad_oe  = 1'b1;
        lad_out = typedir_nibble(kind, wr, idsel);
      end
      ST_ADDR: begin
        lad_oe  = 1'b1;
        lad_out = nibble_of(addr, nib_idx);
      end
      ST_MSIZE: begin
        lad_oe  = 1'b1;
        lad_out = NIB_ZERO;
      end
      ST_WDATA: begin
        lad_oe  = 1'b1;
        lad_out = ph[0] ? wdata[7:4] : wdata[3:0];
      end
      ST_TARH: begin
        lad_oe  = (ph == '0);
        lad_out = NIB_ONES;
      end
      ST_ABORT: begin
        lframe_n = 1'b0;
        lad_oe   = 1'b1;
        lad_out  = NIB_ONES;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lpc_cycle_seq.sv
module lpc_cycle_seq
  import lpc_seq_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int SYNC_LIMIT = 256,
  parameter int ABORT_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [1:0]       cmd_kind,
  input  logic             cmd_incr,
  input  logic [3:0]       cmd_idsel,
  input  logic [31:0]      cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  output logic [7:0]       rx_data,
  output logic             rx_push,
  output logic             lframe_n,
  output logic [3:0]       lad_out,
  output logic             lad_oe,
  input  logic [3:0]       lad_in,
  output logic [3:0]       seq_state,
  output logic             done,
  output logic             ok,
  output logic             err
);
  localparam int PH_W = (ABORT_CLKS > 8) ? $clog2(ABORT_CLKS) : 3;

  seq_state_e      state_q, state_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            wr_q;
  cyc_kind_e       kind_q;
  logic [3:0]      idsel_q;
  logic [3:0]      rd_lo_q;
  logic            done_q, done_d, err_q, err_d;

  // named internal events, also watched by the checker
  logic        accept_w;
  logic        byte_end_w;
  logic        last_nib_w;
  logic        abort_end_w;
  logic        sync_ready_w, sync_error_w, sync_timeout_w;
  logic        last_byte_w;
  logic [31:0] cur_addr_w;

  assign accept_w    = cmd_valid && (state_q == ST_IDLE);
  assign byte_end_w  = (state_q == ST_TART) && ph_q[0];
  assign last_nib_w  = (ph_q == PH_W'(addr_nibbles(kind_q) - 4'd1));
  assign abort_end_w = (ph_q == PH_W'(ABORT_CLKS - 1));

  lpc_seq_cursor #(.LEN_W(LEN_W)) u_cursor (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept_w),
    .ld_addr (cmd_addr),
    .ld_len  (cmd_len),
    .ld_incr (cmd_incr),
    .step    (byte_end_w),
    .addr    (cur_addr_w),
    .last    (last_byte_w)
  );

  lpc_sync_watch #(.SYNC_LIMIT(SYNC_LIMIT)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_sync (state_q == ST_SYNC),
    .lad_in  (lad_in),
    .ready   (sync_ready_w),
    .error   (sync_error_w),
    .timeout (sync_timeout_w)
  );

  lpc_lad_drive #(.PH_W(PH_W)) u_drive (
    .state    (state_q),
    .ph       (ph_q),
    .kind     (kind_q),
    .wr       (wr_q),
    .idsel    (idsel_q),
    .addr     (cur_addr_w),
    .wdata    (tx_data),
    .lframe_n (lframe_n),
    .lad_out  (lad_out),
    .lad_oe   (lad_oe)
  );

  always_comb begin
    state_d = state_q;
    ph_d    = '0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          if (cmd_len == '0) done_d  = 1'b1;
          else               state_d = ST_START;
        end
      end
      ST_START:  state_d = ST_TYPDIR;
      ST_TYPDIR: state_d = ST_ADDR;
      ST_ADDR: begin
        if (last_nib_w) begin
          if (kind_q == KIND_FWH) state_d = ST_MSIZE;
          else                    state_d = wr_q ? ST_WDATA : ST_TARH;
        end else begin
          ph_d = ph_q + PH_W'(1);
        end
      end
      ST_MSIZE: state_d = wr_q ? ST_WDATA : ST_TARH;
      ST_WDATA: begin
        if (ph_q[0]) state_d = ST_TARH;
        else         ph_d = ph_q + PH_W'(1);
      end
      ST_TARH: begin
        if (ph_q[0]) state_d = ST_SYNC;
        else         ph_d = ph_q + PH_W'(1);
      end
      ST_SYNC: begin
        if (sync_error_w || sync_timeout_w) state_d = ST_ABORT;
        else if (sync_ready_w)              state_d = wr_q ? ST_TART : ST_RDATA;
      end
      ST_RDATA: begin
        if (ph_q[0]) state_d = ST_TART;
        else         ph_d = ph_q + PH_W'(1);
      end
      ST_TART: begin
        if (!ph_q[0]) begin
          ph_d = ph_q + PH_W'(1);
        end else if (last_byte_w) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_START;
        end
      end
      ST_ABORT: begin
        if (abort_end_w) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_d   = 1'b1;
        end else begin
          ph_d = ph_q + PH_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      wr_q    <= 1'b0;
      kind_q  <= KIND_IO;
      idsel_q <= '0;
      rd_lo_q <= '0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (accept_w) begin
        wr_q    <= cmd_write;
        kind_q  <= cyc_kind_e'(cmd_kind);
        idsel_q <= cmd_idsel;
      end
      if ((state_q == ST_RDATA) && !ph_q[0]) rd_lo_q <= lad_in;
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign tx_pop    = (state_q == ST_WDATA) && ph_q[0];
  assign rx_push   = (state_q == ST_RDATA) && ph_q[0];
  assign rx_data   = {lad_in, rd_lo_q};
  assign seq_state = state_q;
  assign done      = done_q;
  assign err       = err_q;
  assign ok        = done_q && !err_q;
endmodule

// File: rtl/lpc_cycle_seq_chk.sv
module lpc_cycle_seq_chk #(
  parameter int SYNC_LIMIT = 256,
  parameter int ABORT_CLKS = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] seq_state,
  input logic       lframe_n,
  input logic       lad_oe,
  input logic       tx_pop,
  input logic       rx_push,
  input logic       done,
  input logic       ok,
  input logic       err,
  input logic       sync_ready,
  input logic       sync_timeout
);
  localparam int CW = $clog2(SYNC_LIMIT + 1);
  localparam int AW = $clog2(ABORT_CLKS + 1);

  logic [CW-1:0] sy_cnt;
  logic [AW-1:0] ab_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_cnt <= '0;
      ab_cnt <= '0;
    end else begin
      sy_cnt <= (seq_state == 4'd7)  ? sy_cnt + CW'(1) : '0;
      ab_cnt <= (seq_state == 4'd10) ? ab_cnt + AW'(1) : '0;
    end
  end

  assert_state_legal_R13: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state <= 4'd10);

  assert_frame_only_start_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |-> (seq_state == 4'd1 || seq_state == 4'd10));

  assert_lad_free_in_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 4'd7) |-> !lad_oe);

  assert_ready_leaves_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ready |=> (seq_state == 4'd8 || seq_state == 4'd9));

  assert_sync_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 4'd7) |-> (sy_cnt < CW'(SYNC_LIMIT)));

  assert_timeout_aborts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_timeout |=> (seq_state == 4'd10));

  assert_pop_in_wdata_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (seq_state == 4'd5));

  assert_push_in_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (seq_state == 4'd8));

  assert_abort_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((seq_state == 4'd10) && (ab_cnt < AW'(ABORT_CLKS - 1))) |=> (seq_state == 4'd10));

  assert_abort_short_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 4'd10) |-> (ab_cnt < AW'(ABORT_CLKS)));

  assert_done_in_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (seq_state == 4'd0));

  assert_done_one_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok != err));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind lpc_cycle_seq lpc_cycle_seq_chk #(
  .SYNC_LIMIT (SYNC_LIMIT),
  .ABORT_CLKS (ABORT_CLKS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .seq_state    (seq_state),
  .lframe_n     (lframe_n),
  .lad_oe       (lad_oe),
  .tx_pop       (tx_pop),
  .rx_push      (rx_push),
  .done         (done),
  .ok           (ok),
  .err          (err),
  .sync_ready   (sync_ready_w),
  .sync_timeout (sync_timeout_w)
);

// File: tb/lpc_cycle_seq_bench.sv
`timescale 1ns/1ps
module lpc_cycle_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [1:0]  cmd_kind = 2'd0;
  logic        cmd_incr = 1'b0;
  logic [3:0]  cmd_idsel = 4'd0;
  logic [31:0] cmd_addr = 32'd0;
  logic [7:0]  cmd_len = 8'd0;
  logic [7:0]  tx_data;
  logic        tx_pop;
  logic [7:0]  rx_data;
  logic        rx_push;
  logic        lframe_n;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic [3:0]  lad_in = 4'hF;
  logic [3:0]  seq_state;
  logic        done, ok, err;

  always #2 clk = ~clk;

  lpc_cycle_seq u_lpc_cycle_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_kind(cmd_kind), .cmd_incr(cmd_incr),
    .cmd_idsel(cmd_idsel), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push),
    .lframe_n(lframe_n), .lad_out(lad_out), .lad_oe(lad_oe), .lad_in(lad_in),
    .seq_state(seq_state), .done(done), .ok(ok), .err(err)
  );

  int checks = 0;
  int errors = 0;
  int tx_idx = 0;
  int tx_model = 0;

  function automatic logic [7:0] tx_byte(input int i);
    return 8'(8'hA1 + 29 * i);
  endfunction

  function automatic logic [7:0] rd_byte(input int i);
    return 8'(8'h3C + 17 * i);
  endfunction

  assign tx_data = tx_byte(tx_idx);
  always @(posedge clk) if (rst_n && tx_pop) tx_idx <= tx_idx + 1;

  typedef struct packed {
    logic [3:0] st;
    logic       lf;
    logic       oe;
    logic [3:0] lad;
    logic       pop;
    logic       push;
    logic [7:0] rx;
    logic       dn;
    logic       er;
    logic [3:0] drv;
  } ent_t;

  ent_t q[$];

  function automatic void add(input logic [3:0] st, input logic lf, input logic oe,
                              input logic [3:0] lad, input logic [3:0] drv,
                              input logic pop, input logic push, input logic [7:0] rx,
                              input logic dn, input logic er);
    ent_t e;
    e.st = st; e.lf = lf; e.oe = oe; e.lad = lad; e.drv = drv;
    e.pop = pop; e.push = push; e.rx = rx; e.dn = dn; e.er = er;
    q.push_back(e);
  endfunction

  function automatic string tag(input logic [3:0] s);
    case (s)
      4'd1:       return "R3";
      4'd2:       return "R4";
      4'd3, 4'd4: return "R5";
      4'd5, 4'd6: return "R6";
      4'd7:       return "R7";
      4'd8:       return "R9";
      4'd9:       return "R10";
      4'd10:      return "R11";
      default:    return "R12";
    endcase
  endfunction

  task automatic chk(input bit good, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // expected bus trace of one operation, one entry per clock
  function automatic void build_op(input bit wr, input logic [1:0] kind, input bit incr,
                                   input logic [3:0] idsel, input logic [31:0] addr,
                                   input int len, input int waits, input int err_byte);
    logic [31:0] a;
    logic [3:0]  sn, td;
    logic [7:0]  d, r;
    int n, wl;
    a = addr;
    if (len == 0) begin
      add(0, 1, 0, 0, 4'hF, 0, 0, 0, 1, 0);
      add(0, 1, 0, 0, 4'hF, 0, 0, 0, 0, 0);
      return;
    end
    for (int b = 0; b < len; b++) begin
      sn = (kind == 2'd2) ? (wr ? 4'hE : 4'hD) : 4'h0;
      td = (kind == 2'd2) ? idsel : {(kind == 2'd1) ? 2'b01 : 2'b00, wr, 1'b0};
      n  = (kind == 2'd0) ? 4 : (kind == 2'd1) ? 8 : 7;
      add(1, 0, 1, sn, 4'hF, 0, 0, 0, 0, 0);
      add(2, 1, 1, td, 4'hF, 0, 0, 0, 0, 0);
      for (int k = n - 1; k >= 0; k--) add(3, 1, 1, a[k*4 +: 4], 4'hF, 0, 0, 0, 0, 0);
      if (kind == 2'd2) add(4, 1, 1, 4'h0, 4'hF, 0, 0, 0, 0, 0);
      if (wr) begin
        d = tx_byte(tx_model);
        add(5, 1, 1, d[3:0], 4'hF, 0, 0, 0, 0, 0);
        add(5, 1, 1, d[7:4], 4'hF, 1, 0, 0, 0, 0);
        tx_model++;
      end
      add(6, 1, 1, 4'hF, 4'hF, 0, 0, 0, 0, 0);
      add(6, 1, 0, 4'hF, 4'hF, 0, 0, 0, 0, 0);
      wl = (waits >= 256) ? 256 : waits;
      for (int k = 0; k < wl; k++) add(7, 1, 0, 4'hF, k[0] ? 4'h5 : 4'h6, 0, 0, 0, 0, 0);
      if (waits >= 256 || b == err_byte) begin
        if (waits < 256) add(7, 1, 0, 4'hF, 4'hA, 0, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) add(10, 0, 1, 4'hF, 4'hF, 0, 0, 0, 0, 0);
        add(0, 1, 0, 0, 4'hF, 0, 0, 0, 1, 1);
        add(0, 1, 0, 0, 4'hF, 0, 0, 0, 0, 0);
        return;
      end
      add(7, 1, 0, 4'hF, 4'h0, 0, 0, 0, 0, 0);
      if (!wr) begin
        r = rd_byte(b);
        add(8, 1, 0, 4'hF, r[3:0], 0, 0, 0, 0, 0);
        add(8, 1, 0, 4'hF, r[7:4], 0, 1, r, 0, 0);
      end
      add(9, 1, 0, 4'hF, 4'hF, 0, 0, 0, 0, 0);
      add(9, 1, 0, 4'hF, 4'hF, 0, 0, 0, 0, 0);
      if (incr) a = a + 32'd1;
    end
    add(0, 1, 0, 0, 4'hF, 0, 0, 0, 1, 0);
    add(0, 1, 0, 0, 4'hF, 0, 0, 0, 0, 0);
  endfunction

  task automatic run_op(input bit wr, input logic [1:0] kind, input bit incr,
                        input logic [3:0] idsel, input logic [31:0] addr,
                        input int len, input int waits, input int err_byte, input bit poke);
    ent_t e;
    int idx;
    string t;
    q.delete();
    build_op(wr, kind, incr, idsel, addr, len, waits, err_byte);
    @(negedge clk);
    cmd_write = wr; cmd_kind = kind; cmd_incr = incr; cmd_idsel = idsel;
    cmd_addr = addr; cmd_len = 8'(len); cmd_valid = 1'b1;
    #1;
    chk(cmd_ready == 1'b1, "R2", "ready while idle", 32'(cmd_ready), 1);
    @(posedge clk);
    idx = 0;
    while (q.size() > 0) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (poke && idx == 2) begin
        // R2: a descriptor offered mid-operation must leave the trace untouched
        cmd_valid = 1'b1; cmd_write = ~wr; cmd_kind = 2'd1;
        cmd_addr = 32'hFFFF_FFFF; cmd_len = 8'd9;
      end
      e = q.pop_front();
      lad_in = e.drv;
      #1;
      t = tag(e.st);
      if (poke && idx == 2) chk(cmd_ready == 1'b0, "R2", "ready while busy", 32'(cmd_ready), 0);
      chk(seq_state == e.st, "R13", "status", 32'(seq_state), 32'(e.st));
      chk(lframe_n == e.lf, t, "frame strobe", 32'(lframe_n), 32'(e.lf));
      chk(lad_oe == e.oe, t, "LAD enable", 32'(lad_oe), 32'(e.oe));
      if (e.oe) chk(lad_out == e.lad, t, "LAD nibble", 32'(lad_out), 32'(e.lad));
      chk(tx_pop == e.pop, "R6", "tx pop", 32'(tx_pop), 32'(e.pop));
      chk(rx_push == e.push, "R9", "rx push", 32'(rx_push), 32'(e.push));
      if (e.push) chk(rx_data == e.rx, "R9", "rx byte", 32'(rx_data), 32'(e.rx));
      chk(done == e.dn, "R12", "done", 32'(done), 32'(e.dn));
      chk(err == (e.dn & e.er), "R12", "err", 32'(err), 32'(e.dn & e.er));
      chk(ok == (e.dn & ~e.er), "R12", "ok", 32'(ok), 32'(e.dn & ~e.er));
      idx++;
    end
    cmd_valid = 1'b0;
    chk(tx_idx == tx_model, "R11", "bytes popped so far", 32'(tx_idx), 32'(tx_model));
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not finish, actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(seq_state == 4'd0, "R1", "status in reset", 32'(seq_state), 0);
    chk(lframe_n == 1'b1, "R1", "frame strobe in reset", 32'(lframe_n), 1);
    chk(lad_oe == 1'b0, "R1", "LAD enable in reset", 32'(lad_oe), 0);
    chk(done == 1'b0, "R1", "done in reset", 32'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(seq_state == 4'd0 && lad_oe == 1'b0, "R1", "idle after reset", 32'(seq_state), 0);

    run_op(1, 2'd0, 0, 4'h0, 32'h0000_02F8, 1, 2, -1, 1);   // I/O write, R2 poke
    run_op(0, 2'd0, 0, 4'h0, 32'h0000_0060, 1, 0, -1, 0);   // I/O read, R9
    run_op(0, 2'd1, 1, 4'h0, 32'h000F_FFFE, 3, 1, -1, 0);   // R10 incrementing, nibble carry
    run_op(1, 2'd1, 0, 4'h0, 32'h8000_1234, 2, 3, -1, 0);   // R10 fixed address
    run_op(0, 2'd2, 1, 4'h5, 32'h0FFF_FFF0, 2, 0, -1, 0);   // firmware-hub read, R4 R5
    run_op(1, 2'd2, 0, 4'hA, 32'h00A5_5A5A, 1, 1, -1, 0);   // firmware-hub write
    run_op(0, 2'd0, 1, 4'h0, 32'h0000_0400, 3, 0, 1, 0);    // R11 error on second byte
    run_op(1, 2'd0, 1, 4'h0, 32'h0000_0500, 2, 1, 0, 0);    // R11 write aborted, rest dropped
    run_op(0, 2'd0, 0, 4'h0, 32'h0000_0064, 1, 255, -1, 0); // R8 ready on last allowed clock
    run_op(1, 2'd0, 0, 4'h0, 32'h0000_0080, 1, 256, -1, 0); // R8 timeout
    run_op(1, 2'd0, 0, 4'h0, 32'h0000_0090, 0, 0, -1, 0);   // R14 zero count
    run_op(1, 2'd0, 0, 4'h0, 32'h0000_0091, 1, 0, -1, 0);   // R11 FIFO order intact after abort

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule